// File: doc/BRIEF.md
# AES Round Control Sequencer

This block times a byte-serial AES-128 encryption core without a binary step counter. A 5-bit linear feedback shift register advances once per clock while a block is in flight. It is cut short to a loop of 21 states, which is one cipher round. The datapath uses one round timing throughout:

- 16 byte cycles of round-key addition;
- one cycle in which the rows are rotated;
- 4 cycles in which the column mixing runs alongside the byte substitution of the key word.

The block decodes three reference states of the register into phase strobes. It also raises a pulse on the last state of each loop. That pulse advances the round count, re-arms the key-addition phase and hands over to the output stage after the tenth round.

A start request taken while the sequencer is idle launches ten rounds of 21 cycles. Sixteen output cycles follow, during which the final key addition streams the ciphertext out. A one-cycle done pulse then ends the encryption, 226 clock edges after the edge that took the request. The key store is held for the single row-rotation cycle of each round. Column mixing is withheld in the tenth round, but the key-word substitution slot still runs.

Top module: `aes_round_seq`

## Requirements
- R1: After reset, and whenever idle, every strobe, `round_wrap`, `last_round` and `done` are low, `key_en` is low, `round_idx` is 0 and `seq_state` holds the seed 5'h01.
- R2: `seq_state` is a 5-bit shift register. On each step, bits [3:0] move up to [4:1] and the new bit 0 is bit 4 XOR bit 0 (taps at positions 5 and 1). It starts from the seed 5'h01 at step 0 of each round, passes through 21 distinct non-zero states, and reloads the seed after the 21st.
- R3: In each round, `ark_phase` is high for steps 0 to 15, `sr_phase` for step 16 only, and `subword_phase` for steps 17 to 20. At most one of `sr_phase`, `subword_phase` and `out_phase` is high in any cycle.
- R4: While an encryption is in flight, `key_en` is high in every cycle except the row-rotation cycle (`sr_phase`), where it is low.
- R5: `round_wrap` is a one-cycle pulse on step 20 of every round, so it recurs every 21 cycles. `round_idx` counts 1 through 10, advancing after each pulse.
- R6: `last_round` is high for all 21 cycles of round 10 only. In that round `mix_en` stays low, while `subword_phase` still covers steps 17 to 20. In rounds 1 to 9, `mix_en` equals `subword_phase`.
- R7: After round 10, `out_phase` and `ark_phase` are high for 16 cycles with `key_en` high and `round_idx` at 10. `seq_state` again runs from the seed during these cycles.
- R8: `done` is high for exactly one cycle, seen after the 226th clock edge that follows the edge which took `start`. In that cycle the sequencer is idle and can take a new `start`.
- R9: `start` has no effect while rounds or output cycles are in progress. The phase, round count and latency of the running block are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken only while idle |
| ark_phase | output | 1 | Round-key addition byte cycle (also during output) |
| sr_phase | output | 1 | Row-rotation cycle |
| subword_phase | output | 1 | Column-mix / key-word substitution cycle |
| mix_en | output | 1 | Column mixing enabled (subword phase outside round 10) |
| key_en | output | 1 | Key store clock enable |
| out_phase | output | 1 | Ciphertext output cycle |
| round_wrap | output | 1 | Pulse on the final cycle of each round |
| round_idx | output | 4 | Current round number, 0 when idle |
| last_round | output | 1 | Round 10 in progress |
| done | output | 1 | One-cycle completion pulse |
| seq_state | output | 5 | Current shift-register state |

## Verification
The hardest situations to reach are two boundaries. One is a launch request that arrives in the very cycle `done` is high. The other is a request held high, or pulsed at random, all through a block in flight. Only these show whether the idle check and the hand-over from the output stage are cycle-exact.

The stimulus therefore forces a back-to-back launch on the done cycle and holds `start` high across one whole run. Other runs get random idle gaps and random request noise from a fixed seed. Every output is compared in every cycle against a model indexed by the edge count since launch.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

    localparam int SEQ_W = 5;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_ROUNDS = 2'd1,
        MODE_OUTPUT = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_KEYADD = 2'd0,
        PH_SHIFT  = 2'd1,
        PH_MIX    = 2'd2
    } phase_e;

    // One shift step: bits move toward the MSB, feedback enters at bit 0.
    function automatic seq_t seq_step(seq_t s, int tap_hi, int tap_lo);
        seq_t n;
        n = {s[SEQ_W-2:0], s[tap_hi-1] ^ s[tap_lo-1]};
        return n;
    endfunction

    // State reached after a given number of steps from the seed.
    function automatic seq_t seq_at(seq_t seed, int tap_hi, int tap_lo, int steps);
        seq_t s;
        s = seed;
        for (int i = 0; i < steps; i++) begin
            s = seq_step(s, tap_hi, tap_lo);
        end
        return s;
    endfunction

endpackage

// File: rtl/aes_seq_lfsr.sv
module aes_seq_lfsr
    import aes_seq_pkg::*;
#(
    parameter int   TAP_HI     = 5,
    parameter int   TAP_LO     = 1,
    parameter seq_t SEED       = 5'h01,
    parameter int   KEYADD_LEN = 16,
    parameter int   ROUND_LEN  = 21,
    parameter int   OUT_LEN    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output seq_t state,
    output logic at_keyadd_end,
    output logic at_shift,
    output logic at_term,
    output logic at_out_end
);

    localparam seq_t ST_KEYADD_END = seq_at(SEED, TAP_HI, TAP_LO, KEYADD_LEN - 1);
    localparam seq_t ST_SHIFT      = seq_at(SEED, TAP_HI, TAP_LO, KEYADD_LEN);
    localparam seq_t ST_TERM       = seq_at(SEED, TAP_HI, TAP_LO, ROUND_LEN - 1);
    localparam seq_t ST_OUT_END    = seq_at(SEED, TAP_HI, TAP_LO, OUT_LEN - 1);

    typedef struct packed {
        seq_t state;
    } lfsr_reg_t;

    lfsr_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.state = SEED;
        end else if (r_q.state == ST_TERM) begin
            r_d.state = SEED;
        end else begin
            r_d.state = seq_step(r_q.state, TAP_HI, TAP_LO);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign state         = r_q.state;
    assign at_keyadd_end = (r_q.state == ST_KEYADD_END);
    assign at_shift      = (r_q.state == ST_SHIFT);
    assign at_term       = (r_q.state == ST_TERM);
    assign at_out_end    = (r_q.state == ST_OUT_END);

    AST_SEQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state != '0); // R2

endmodule

// File: rtl/aes_seq_phase.sv
module aes_seq_phase
    import aes_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   launch,
    input  logic   wrap,
    input  logic   in_rounds,
    input  logic   at_keyadd_end,
    input  logic   at_shift,
    output phase_e phase
);

    typedef struct packed {
        phase_e phase;
    } phase_reg_t;

    phase_reg_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (launch || wrap || !in_rounds) begin
            p_d.phase = PH_KEYADD;
        end else if (at_keyadd_end) begin
            p_d.phase = PH_SHIFT;
        end else if (at_shift) begin
            p_d.phase = PH_MIX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.phase <= PH_KEYADD;
        end else begin
            p_q <= p_d;
        end
    end

    assign phase = p_q.phase;

    AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rounds && p_q.phase == PH_SHIFT) |=> (p_q.phase != PH_SHIFT)); // R3

endmodule

// File: rtl/aes_seq_round.sv
module aes_seq_round #(
    parameter int ROUNDS = 10,
    parameter int RW     = $clog2(ROUNDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          wrap,
    input  logic          clear,
    output logic [RW-1:0] round,
    output logic          is_last
);

    localparam logic [RW-1:0] LAST = RW'(ROUNDS);

    typedef struct packed {
        logic [RW-1:0] round;
    } round_reg_t;

    round_reg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (launch) begin
            c_d.round = RW'(1);
        end else if (clear) begin
            c_d.round = '0;
        end else if (wrap && c_q.round != LAST) begin
            c_d.round = c_q.round + RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.round <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign round   = c_q.round;
    assign is_last = (c_q.round == LAST);

    AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.round <= LAST); // R5
    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !is_last && !launch) |=> (c_q.round == $past(c_q.round) + RW'(1))); // R5

endmodule

// File: rtl/aes_round_seq.sv
module aes_round_seq
    import aes_seq_pkg::*;
#(
    parameter int   TAP_HI     = 5,
    parameter int   TAP_LO     = 1,
    parameter seq_t SEED       = 5'h01,
    parameter int   KEYADD_LEN = 16,
    parameter int   MIX_LEN    = 4,
    parameter int   ROUNDS     = 10,
    parameter int   OUT_LEN    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       ark_phase,
    output logic       sr_phase,
    output logic       subword_phase,
    output logic       mix_en,
    output logic       key_en,
    output logic       out_phase,
    output logic       round_wrap,
    output logic [3:0] round_idx,
    output logic       last_round,
    output logic       done,
    output logic [4:0] seq_state
);

    localparam int ROUND_LEN = KEYADD_LEN + 1 + MIX_LEN;
    localparam int RW        = $clog2(ROUNDS + 1);

    typedef struct packed {
        mode_e mode;
        logic  done;
    } top_reg_t;

    top_reg_t t_d, t_q;

    logic          launch, wrap, final_wrap, out_end, run, in_rounds;
    logic          at_keyadd_end, at_shift, at_term, at_out_end, is_last;
    seq_t          state;
    phase_e        phase;
    logic [RW-1:0] round;

    assign in_rounds  = (t_q.mode == MODE_ROUNDS);
    assign launch     = start && (t_q.mode == MODE_IDLE);
    assign wrap       = in_rounds && at_term;
    assign final_wrap = wrap && is_last;
    assign out_end    = (t_q.mode == MODE_OUTPUT) && at_out_end;
    assign run        = (t_q.mode != MODE_IDLE) && !out_end;

    always_comb begin
        t_d      = t_q;
        t_d.done = out_end;
        unique case (t_q.mode)
            MODE_IDLE:   if (launch)     t_d.mode = MODE_ROUNDS;
            MODE_ROUNDS: if (final_wrap) t_d.mode = MODE_OUTPUT;
            MODE_OUTPUT: if (out_end)    t_d.mode = MODE_IDLE;
            default:                     t_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.mode <= MODE_IDLE;
            t_q.done <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    aes_seq_lfsr #(
        .TAP_HI    (TAP_HI),
        .TAP_LO    (TAP_LO),
        .SEED      (SEED),
        .KEYADD_LEN(KEYADD_LEN),
        .ROUND_LEN (ROUND_LEN),
        .OUT_LEN   (OUT_LEN)
    ) u_lfsr (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .state        (state),
        .at_keyadd_end(at_keyadd_end),
        .at_shift     (at_shift),
        .at_term      (at_term),
        .at_out_end   (at_out_end)
    );

    aes_seq_phase u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .wrap         (wrap),
        .in_rounds    (in_rounds),
        .at_keyadd_end(at_keyadd_end),
        .at_shift     (at_shift),
        .phase        (phase)
    );

    aes_seq_round #(
        .ROUNDS(ROUNDS),
        .RW    (RW)
    ) u_round (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .wrap   (wrap),
        .clear  (out_end),
        .round  (round),
        .is_last(is_last)
    );

    assign out_phase     = (t_q.mode == MODE_OUTPUT);
    assign ark_phase     = (in_rounds && phase == PH_KEYADD) || out_phase;
    assign sr_phase      = in_rounds && phase == PH_SHIFT;
    assign subword_phase = in_rounds && phase == PH_MIX;
    assign last_round    = in_rounds && is_last;
    assign mix_en        = subword_phase && !is_last;
    assign key_en        = (t_q.mode != MODE_IDLE) && !sr_phase;
    assign round_wrap    = wrap;
    assign round_idx     = 4'(round);
    assign done          = t_q.done;
    assign seq_state     = 5'(state);

    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sr_phase |-> !key_en); // R4
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_phase, subword_phase, out_phase})); // R3
    AST_MIX_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_round |-> !mix_en); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_WRAP_TO_KEYADD: assert property (@(posedge clk) disable iff (!rst_n)
        (round_wrap && !last_round) |=> (ark_phase && !out_phase)); // R5

endmodule

// File: tb/aes_round_seq_tb.sv
module aes_round_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ark_phase, sr_phase, subword_phase, mix_en, key_en, out_phase;
    logic       round_wrap, last_round, done;
    logic [3:0] round_idx;
    logic [4:0] seq_state;

    int n_checks = 0;
    int n_fail   = 0;
    int edges    = 0;

    always #4 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    aes_round_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .ark_phase    (ark_phase),
        .sr_phase     (sr_phase),
        .subword_phase(subword_phase),
        .mix_en       (mix_en),
        .key_en       (key_en),
        .out_phase    (out_phase),
        .round_wrap   (round_wrap),
        .round_idx    (round_idx),
        .last_round   (last_round),
        .done         (done),
        .seq_state    (seq_state)
    );

    function automatic logic [4:0] ref_state(int n);
        logic [4:0] s;
        s = 5'h01;
        for (int i = 0; i < n; i++) s = {s[3:0], s[4] ^ s[0]};
        return s;
    endfunction

    task automatic chk(input string req, input string name, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", req, name, act, exp, edges);
        end
    endtask

    // t = -1 idle; 0..209 rounds; 210..225 output; 226 done cycle
    task automatic check_model(input int t);
        int r, s, e_ark, e_sr, e_sub, e_mix, e_key, e_out, e_wrap, e_last, e_done, e_round, e_state;
        e_ark = 0; e_sr = 0; e_sub = 0; e_mix = 0; e_key = 0; e_out = 0;
        e_wrap = 0; e_last = 0; e_done = 0; e_round = 0; e_state = 1;
        if (t >= 0 && t < 210) begin
            r = t / 21 + 1; s = t % 21;
            e_ark = (s < 16) ? 1 : 0;
            e_sr = (s == 16) ? 1 : 0;
            e_sub = (s >= 17) ? 1 : 0;
            e_mix = (e_sub == 1 && r != 10) ? 1 : 0;
            e_key = 1 - e_sr;
            e_wrap = (s == 20) ? 1 : 0;
            e_last = (r == 10) ? 1 : 0;
            e_round = r;
            e_state = int'(ref_state(s));
        end else if (t >= 210 && t < 226) begin
            e_ark = 1; e_out = 1; e_key = 1; e_round = 10;
            e_state = int'(ref_state(t - 210));
        end else if (t == 226) begin
            e_done = 1;
        end
        chk((t < 0) ? "R1" : "R3", "ark_phase", int'(ark_phase), e_ark);
        chk("R3", "sr_phase", int'(sr_phase), e_sr);
        chk("R3", "subword_phase", int'(subword_phase), e_sub);
        chk("R6", "mix_en", int'(mix_en), e_mix);
        chk("R4", "key_en", int'(key_en), e_key);
        chk("R7", "out_phase", int'(out_phase), e_out);
        chk("R5", "round_wrap", int'(round_wrap), e_wrap);
        chk("R6", "last_round", int'(last_round), e_last);
        chk("R8", "done", int'(done), e_done);
        chk((t < 0) ? "R1" : "R5", "round_idx", int'(round_idx), e_round);
        chk("R2", "seq_state", int'(seq_state), e_state);
    endtask

    initial begin
        int  mt, runs, gap, idle_cnt, start_edge, last_wrap, cyc;
        bit  hung;
        mt = -1; runs = 0; gap = 3; idle_cnt = 0; start_edge = 0; last_wrap = -1;
        cyc = 0; hung = 0;
        void'($urandom(32'h5eed_0a35));

        // reset state, R1
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_model(-1);
        end
        rst_n = 1'b1;

        while (runs < 8 || mt != -1) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                hung = 1;
                break;
            end
            check_model(mt);

            // explicit latency and period checks
            if (done) chk("R8", "launch_to_done_edges", edges - start_edge, 226);
            if (round_wrap) begin
                if (last_wrap >= 0) chk("R5", "wrap_period", edges - last_wrap, 21);
                last_wrap = edges;
            end

            // choose start for the coming edge
            if (mt == -1 || mt == 226) begin
                if (runs >= 8) start = 1'b0;
                else if (mt == 226 && gap == 0) start = 1'b1;   // launch in the done cycle
                else if (mt == -1 && idle_cnt >= gap) start = 1'b1;
                else start = 1'b0;
            end else if (runs == 3) begin
                start = 1'b1;                                   // R9: held high through a run
            end else begin
                start = (($urandom % 8) == 0);                  // R9: random noise while busy
            end

            if (mt == -1 || mt == 226) begin
                if (start) begin
                    mt = 0; runs++; idle_cnt = 0;
                    start_edge = edges + 1; last_wrap = -1;
                    gap = (runs == 1) ? 0 : int'($urandom % 6);
                end else begin
                    mt = -1;
                    idle_cnt++;
                end
            end else begin
                mt++;
            end
        end
        start = 1'b0;

        if (hung) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 20000);
        end else begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check_model(-1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule